// File: doc/BRIEF.md
# Serial Register-Access Port

This block is a slave control port that lets a host microcontroller read and write a small bank of 8-bit configuration registers over a four-wire serial link. The link has an active-low select (`sel_n`), a serial clock (`sck`), a host-to-port data line (`sdi`) and a port-to-host data line (`sdo`) with a separate output enable (`sdo_oe`) that stands in for the tri-state driver. The serial inputs are assumed to be already synchronous to the block clock `clk`. The block finds serial-clock edges by comparing each `sck` sample with the one before it.

Each transaction opens with an identification byte. Its upper seven bits must equal the chip identity, and its lowest bit selects the direction. A write then carries a pointer byte and any number of data bytes. A read sends data back, starting with the register the pointer names. The pointer persists between transactions and advances by one after every data byte, so block transfers need no repeated pointer. A write that stops after the pointer byte only moves the pointer, which is how a host picks the start of a later read. The register contents are exposed on a flat output bus.

The controller is one state machine with these states. IDLE: select is high. CHIP: receiving the identification byte. PTR: receiving the pointer byte. WR: receiving write data. RD: driving read data. SKIP: the identification did not match. These are the transitions. IDLE goes to CHIP when select falls. CHIP goes to PTR after 8 bits with a match and the direction bit at 0. CHIP goes to RD after 8 bits with a match and the direction bit at 1. CHIP goes to SKIP after 8 bits with no match. PTR goes to WR after 8 bits. WR, RD and SKIP hold until select rises. Any state goes to IDLE when `sel_n` is high.

Top module: `spi_regport`

## Requirements
- R1: After reset every register reads 0x00, `sdo_oe` is low and `sdo` is 0.
- R2: The first byte is taken MSB first. Its bits [7:1] must equal CHIP_ID (default 7'b1001111) and its bit 0 selects a read (1) or a write (0). So 0x9E opens a write and 0x9F opens a read.
- R3: If the identification byte does not match, every later bit is ignored until select rises: no register changes and `sdo_oe` stays low.
- R4: In a write, the second byte (MSB first) loads the pointer. A write that ends after that byte changes no register.
- R5: Write data is sampled on rising `sck`, MSB first. Each complete byte is stored at the current pointer. Registers change only after a rising `sck` edge.
- R6: The pointer advances by one after each data byte, in both reads and writes. It wraps from 0xFF to 0x00 and persists across transactions.
- R7: In a read, the falling `sck` edge that ends the identification byte drives the MSB of the register at the pointer. Each later falling edge drives the next bit, and the next byte's MSB follows bit 0 directly. `sdo` changes only after a falling `sck` edge.
- R8: `sdo_oe` rises only on a falling `sck` edge in the read data phase. It is low in every other phase and in the cycle after `sel_n` is sampled high.
- R9: Raising `sel_n` mid-transfer aborts it. A partial byte is discarded and the bit count restarts. A partly sent read byte does not advance the pointer.
- R10: Writes to pointer values at or above NUM_REGS are discarded, and reads from them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low transaction select |
| sck | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Drive enable for `sdo`; low means high impedance |
| regs_flat | output | NUM_REGS*8 | Register bank, register i at bits [8i+7:8i] |

## Verification
Two functions meet on the same serial-clock edge. One is the pointer advance at the end of a data byte. The other is either storing the byte at the old pointer (in a write) or loading the next byte from the new pointer (in a read). The bench drives block transfers that cross the end of the implemented range and the 0xFF-to-0x00 wrap. It then compares every register and every read bit against a model indexed by a pointer the bench keeps itself. A separate case aborts a read mid-byte and re-reads the same register, which shows that a partial byte does not advance the pointer.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHIP,
        ST_PTR,
        ST_WR,
        ST_RD,
        ST_SKIP
    } port_state_e;

endpackage

// File: rtl/spi_regport_edge.sv
module spi_regport_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic sck_rise,
    output logic sck_fall
);

    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign sck_rise = sck & ~sck_q;
    assign sck_fall = ~sck & sck_q;

endmodule

// File: rtl/spi_regport_regs.sv
module spi_regport_regs #(
    parameter int NUM_REGS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [7:0]            addr,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    logic [7:0] regs_q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         regs_q[i] <= 8'h00;
            else if (we && addr == 8'(i))       regs_q[i] <= wdata;
        end
        assign regs_flat[i*8 +: 8] = regs_q[i];
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == 8'(i)) rdata = regs_q[i];
        end
    end

endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int         NUM_REGS = 16,
    parameter logic [6:0] CHIP_ID  = 7'b1001111
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_n,
    input  logic                  sck,
    input  logic                  sdi,
    output logic                  sdo,
    output logic                  sdo_oe,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    port_state_e        state_q, state_d;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-2:0]  rx_q;
    logic [BYTE_W-1:0]  tx_q;
    logic [7:0]         ptr_q;
    logic [BYTE_W-1:0]  byte_in;
    logic [7:0]         rd_byte;
    logic               sck_rise, sck_fall;
    logic               byte_done;
    logic               wr_en;

    spi_regport_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    assign byte_in   = {rx_q, sdi};
    assign byte_done = sck_rise && (bit_cnt == LAST_BIT);
    assign wr_en     = !sel_n && (state_q == ST_WR) && byte_done;

    spi_regport_regs #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_en),
        .addr      (ptr_q),
        .wdata     (byte_in),
        .rdata     (rd_byte),
        .regs_flat (regs_flat)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (sel_n) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_CHIP;
                ST_CHIP: begin
                    if (byte_done) begin
                        if (byte_in[7:1] != CHIP_ID) state_d = ST_SKIP;
                        else if (byte_in[0])         state_d = ST_RD;
                        else                         state_d = ST_PTR;
                    end
                end
                ST_PTR:  if (byte_done) state_d = ST_WR;
                ST_WR:   state_d = ST_WR;
                ST_RD:   state_d = ST_RD;
                ST_SKIP: state_d = ST_SKIP;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            ptr_q   <= 8'h00;
            sdo     <= 1'b0;
            sdo_oe  <= 1'b0;
        end else if (sel_n) begin
            bit_cnt <= '0;
            sdo_oe  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_CHIP, ST_PTR, ST_WR: begin
                    if (sck_rise) begin
                        rx_q    <= byte_in[BYTE_W-2:0];
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST_BIT) begin
                            if (state_q == ST_PTR) ptr_q <= byte_in;
                            if (state_q == ST_WR)  ptr_q <= ptr_q + 8'd1;
                        end
                    end
                end
                ST_RD: begin
                    if (sck_fall) begin
                        sdo_oe  <= 1'b1;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == '0) begin
                            sdo  <= rd_byte[7];
                            tx_q <= {rd_byte[6:0], 1'b0};
                        end else begin
                            sdo  <= tx_q[7];
                            tx_q <= {tx_q[6:0], 1'b0};
                        end
                        if (bit_cnt == LAST_BIT) ptr_q <= ptr_q + 8'd1;
                    end
                end
                ST_IDLE, ST_SKIP: begin
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
    parameter int NUM_REGS = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sel_n,
    input logic                  sck,
    input logic                  sdo,
    input logic                  sdo_oe,
    input logic [NUM_REGS*8-1:0] regs_flat
);

    logic sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck;
    end

    // R8
    sel_high_floats_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !sdo_oe);

    // R8
    oe_rises_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(sck_d && !sck));

    // R7
    sdo_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sck_d && !sck) |=> $stable(sdo));

    // R5
    regs_move_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sck && !sck_d) |=> $stable(regs_flat));

    // R9
    deselect_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> $stable(regs_flat));

endmodule

bind spi_regport spi_regport_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .sck       (sck),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .regs_flat (regs_flat)
);

// File: tb/spi_regport_tb.sv
module spi_regport_tb;

    localparam int NREG = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sel_n = 1'b1;
    logic            sck = 1'b0;
    logic            sdi = 1'b0;
    logic            sdo;
    logic            sdo_oe;
    logic [NREG*8-1:0] regs_flat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] model [NREG];

    always #10 clk = ~clk;

    spi_regport #(.NUM_REGS(NREG)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_n),
        .sck       (sck),
        .sdi       (sdi),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .regs_flat (regs_flat)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sdi = b[i];
            wait_clk(4);
            sck = 1'b1;
            wait_clk(4);
            sck = 1'b0;
            wait_clk(4);
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        put_bits(b, 8);
    endtask

    // R7: sample before each rise, confirm sdo holds across the rise
    task automatic get_bits(output logic [7:0] b, input int n);
        b = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            logic held;
            b[i] = sdo;
            held = sdo;
            check("R8 oe during read", 32'(sdo_oe), 32'd1);
            sck = 1'b1;
            wait_clk(4);
            check("R7 sdo held over rise", 32'(sdo), 32'(held));
            sck = 1'b0;
            wait_clk(4);
        end
    endtask

    task automatic begin_tx();
        sel_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic end_tx();
        sel_n = 1'b1;
        wait_clk(4);
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREG; i++)
            check(req, 32'(regs_flat[i*8 +: 8]), 32'(model[i]));
    endtask

    task automatic set_ptr(input logic [7:0] p);
        begin_tx();
        put_byte(8'h9E);
        put_byte(p);
        end_tx();
    endtask

    task automatic read_expect(input int n, input logic [7:0] first_ptr, input string req);
        logic [7:0] p;
        logic [7:0] got;
        p = first_ptr;
        begin_tx();
        put_byte(8'h9F);
        for (int k = 0; k < n; k++) begin
            get_bits(got, 8);
            check(req, 32'(got), (p < NREG) ? 32'(model[p[3:0]]) : 32'h0);
            p = p + 8'd1;
        end
        end_tx();
        check("R8 oe low after read", 32'(sdo_oe), 32'd0);
    endtask

    function automatic logic [7:0] pat(input int pass, input int i);
        return 8'((i * 37 + 11 + pass * 101) & 255);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);

        // R1 reset state
        check("R1 oe", 32'(sdo_oe), 32'd0);
        check("R1 sdo", 32'(sdo), 32'd0);
        check_regs("R1 regs");

        // R5 R6 block writes and R7 block reads, two patterns
        for (int pass = 0; pass < 2; pass++) begin
            begin_tx();
            put_byte(8'h9E);            // R2 write opener
            put_byte(8'h00);
            for (int i = 0; i < NREG; i++) begin
                put_byte(pat(pass, i));
                model[i] = pat(pass, i);
            end
            end_tx();
            check_regs("R5 R6 block write");
            set_ptr(8'h00);
            check_regs("R4 pointer-only write");
            read_expect(NREG, 8'h00, "R7 R6 block read");
        end

        // R10 R6 wrap on write across unimplemented space
        begin_tx();
        put_byte(8'h9E);
        put_byte(8'hFE);
        put_byte(8'hA1);
        put_byte(8'hB2);
        put_byte(8'hC3);
        put_byte(8'hD4);
        end_tx();
        model[0] = 8'hC3;
        model[1] = 8'hD4;
        check_regs("R10 R6 write wrap");

        // R10 read past end returns zero
        set_ptr(8'h0E);
        read_expect(4, 8'h0E, "R10 read past end");
        // R6 read wrap
        set_ptr(8'hFF);
        read_expect(2, 8'hFF, "R6 read wrap");
        // R6 pointer persists: previous read left it at 0x01
        read_expect(1, 8'h01, "R6 pointer persists");

        // R3 mismatched identity, write direction
        begin_tx();
        put_byte(8'h9C);
        put_byte(8'h03);
        put_byte(8'h55);
        check("R3 oe low on mismatch", 32'(sdo_oe), 32'd0);
        end_tx();
        begin_tx();
        put_byte(8'h1E);
        put_byte(8'h04);
        put_byte(8'h66);
        end_tx();
        check_regs("R3 mismatch write ignored");
        // R3 mismatched identity, read direction
        begin_tx();
        put_byte(8'h9D);
        put_byte(8'hFF);
        check("R3 no drive on mismatched read", 32'(sdo_oe), 32'd0);
        end_tx();
        // R2 pointer untouched by mismatches: still 0x02
        read_expect(1, 8'h02, "R2 R3 pointer kept");

        // R4 pointer-only write picks read start
        set_ptr(8'h05);
        check_regs("R4 no register change");
        read_expect(2, 8'h05, "R4 read from chosen pointer");

        // R9 abort mid write byte
        begin_tx();
        put_byte(8'h9E);
        put_byte(8'h07);
        put_bits(8'hFF, 4);
        end_tx();
        check_regs("R9 partial write discarded");
        // R9 bit count restarts: full write after abort lands correctly
        begin_tx();
        put_byte(8'h9E);
        put_byte(8'h07);
        put_byte(8'h3C);
        end_tx();
        model[7] = 8'h3C;
        check_regs("R9 clean write after abort");

        // R9 abort mid read byte keeps pointer
        set_ptr(8'h07);
        begin_tx();
        put_byte(8'h9F);
        get_bits(got, 3);
        check("R9 partial read bits", 32'(got[7:5]), 32'(model[7][7:5]));
        sel_n = 1'b1;
        wait_clk(1);
        check("R9 oe drops on deselect", 32'(sdo_oe), 32'd0);
        wait_clk(3);
        read_expect(1, 8'h07, "R9 pointer not advanced");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule